// File: doc/BRIEF.md
# Host-to-PCI Initiator Command Selector

This block sits between the host side of a bridge and the PCI initiator engine. A host request names an access kind (memory read, memory write, configuration read, configuration write or interrupt-acknowledge read), a word count and an address. The block samples the current control settings when it accepts the request. These settings are an invalidate-enable bit, a cache line size, a host/satellite mode bit and a bus-error-reporting enable. From them it picks the four-bit PCI command code, starts one bus cycle and waits for the bus engine to report completion.

When the bus engine reports the outcome, the block builds the completion for the host. Normally the completion carries the read data. A configuration read that draws no target response becomes either a bus error or an error-free all-ones word, depending on the latched reporting enable. Any other access that gets no response always reports an error. An interrupt acknowledge in satellite mode is refused without touching the bus, and so is an unknown kind.

Top module: `pci_cmd_selector`

## Requirements
- R1: After reset, req_ready is 1, and bus_start and cpl_valid are 0.
- R2: A memory write (kind 1) issues command 0xF only when the invalidate enable is 1, the line size is nonzero and the word count is strictly greater than the line size.
- R3: A memory write that fails any condition of R2 issues command 0x7. This includes a word count equal to the line size.
- R4: A memory read (kind 0) issues command 0x6 whatever the line size and word count.
- R5: A configuration read (kind 2) issues 0xA and a configuration write (kind 3) issues 0xB. bus_addr equals the request address unchanged, including bits 1:0 (00 selects Type 0, 01 selects Type 1).
- R6: An interrupt-acknowledge read (kind 4) in host mode issues command 0x0, and its completion returns the bus data without error.
- R7: An interrupt acknowledge in satellite mode, or a kind code of 5 to 7, never raises bus_start. It completes with cpl_err = 1 and cpl_rdata = 0 in the cycle after acceptance.
- R8: A configuration read with no response and reporting enabled completes with cpl_err = 1 and cpl_rdata = 0.
- R9: A configuration read with no response and reporting disabled completes with cpl_err = 0 and cpl_rdata all ones.
- R10: bus_start is high for exactly the one cycle after acceptance. cpl_valid is high for exactly the one cycle after the cycle in which bus_done is seen. req_ready stays low from acceptance until that completion cycle has ended.
- R11: A no-response outcome on a memory read, memory write, configuration write or interrupt acknowledge completes with cpl_err = 1, whatever the reporting enable says.
- R12: Control settings are sampled at acceptance. Changing them while a cycle is outstanding changes neither bus_cmd nor the completion.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Host request present |
| req_kind | input | 3 | 0 mem read, 1 mem write, 2 cfg read, 3 cfg write, 4 int-ack read |
| req_words | input | WCNT_W (9) | Burst length in words |
| req_addr | input | ADDR_W (32) | Target address; cfg bits 1:0 carry the type |
| req_ready | output | 1 | Block idle and able to accept |
| cfg_mwi_en | input | 1 | Allow write-and-invalidate |
| cfg_line_size | input | CLS_W (8) | Cache line size in words, 0 = unset |
| cfg_host_mode | input | 1 | 1 host, 0 satellite |
| cfg_berr_en | input | 1 | Report no-response config reads as errors |
| bus_start | output | 1 | One-cycle start of a bus cycle |
| bus_cmd | output | 4 | PCI command code, held until completion |
| bus_addr | output | ADDR_W (32) | Address for the bus cycle |
| bus_done | input | 1 | Bus engine finished the cycle |
| bus_noresp | input | 1 | No target answered (with bus_done) |
| bus_rdata | input | DATA_W (32) | Read data (with bus_done) |
| cpl_valid | output | 1 | One-cycle completion to host |
| cpl_err | output | 1 | Completion is a bus error |
| cpl_rdata | output | DATA_W (32) | Completion read data |

## Verification
A wrong command choice shows on bus_cmd in the single cycle that bus_start is high, so the selection rules are checked right at the start pulse for each boundary of the line-size comparison. A sequencer stuck in the wrong state shows at once: either bus_start fails to drop after one cycle, or req_ready fails to return after the completion pulse. A wrong completion register shows on cpl_err or cpl_rdata in the one cycle that cpl_valid is high. Latching faults only appear when the settings are changed mid-cycle, so one scenario toggles them while a cycle is outstanding.

// File: rtl/pci_sel_pkg.sv
// Package: shared kinds, command codes and sequencer states for the
// host-to-PCI command selector. Assumes 4-bit PCI command encoding.
package pci_sel_pkg;

    typedef enum logic [2:0] {
        K_MEM_RD  = 3'd0,
        K_MEM_WR  = 3'd1,
        K_CFG_RD  = 3'd2,
        K_CFG_WR  = 3'd3,
        K_IACK_RD = 3'd4
    } req_kind_e;

    localparam logic [3:0] CMD_IACK   = 4'h0;
    localparam logic [3:0] CMD_MEM_RD = 4'h6;
    localparam logic [3:0] CMD_MEM_WR = 4'h7;
    localparam logic [3:0] CMD_CFG_RD = 4'hA;
    localparam logic [3:0] CMD_CFG_WR = 4'hB;
    localparam logic [3:0] CMD_MWI    = 4'hF;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_ISSUE = 2'd1,
        ST_WAIT  = 2'd2,
        ST_CPL   = 2'd3
    } seq_state_e;

    typedef struct packed {
        logic [3:0] cmd;
        logic       is_read;
        logic       is_cfg_rd;
        logic       reject;
    } cmd_sel_t;

endpackage

// File: rtl/pci_cmd_decode.sv
// Module: pci_cmd_decode
// Purely combinational choice of the PCI command for one request.
// Assumes the caller registers the result at acceptance.
module pci_cmd_decode
    import pci_sel_pkg::*;
#(
    parameter int WCNT_W = 9,
    parameter int CLS_W  = 8
) (
    input  logic [2:0]        kind,
    input  logic [WCNT_W-1:0] words,
    input  logic              mwi_en,
    input  logic [CLS_W-1:0]  line_size,
    input  logic              host_mode,
    output cmd_sel_t          sel
);
    localparam int CMP_W = (WCNT_W > CLS_W) ? WCNT_W : CLS_W;

    logic [CMP_W-1:0] words_ext;
    logic [CMP_W-1:0] line_ext;
    logic             line_set;
    logic             longer_than_line;

    // Widen both operands so the comparison is unsigned and lossless.
    always_comb begin
        words_ext        = CMP_W'(words);
        line_ext         = CMP_W'(line_size);
        line_set         = (line_size != '0);
        longer_than_line = (words_ext > line_ext);
    end

    // Map kind and settings to command code and completion attributes.
    always_comb begin
        sel = '{cmd: CMD_MEM_RD, is_read: 1'b0, is_cfg_rd: 1'b0, reject: 1'b0};
        case (kind)
            K_MEM_RD: begin
                sel.cmd     = CMD_MEM_RD;
                sel.is_read = 1'b1;
            end
            K_MEM_WR: begin
                sel.cmd = (mwi_en && line_set && longer_than_line) ? CMD_MWI : CMD_MEM_WR;
            end
            K_CFG_RD: begin
                sel.cmd       = CMD_CFG_RD;
                sel.is_read   = 1'b1;
                sel.is_cfg_rd = 1'b1;
            end
            K_CFG_WR: begin
                sel.cmd = CMD_CFG_WR;
            end
            K_IACK_RD: begin
                sel.cmd     = CMD_IACK;
                sel.is_read = 1'b1;
                sel.reject  = !host_mode;
            end
            default: begin
                sel.reject = 1'b1;
            end
        endcase
    end

endmodule

// File: rtl/pci_seq_ctrl.sv
// Module: pci_seq_ctrl
// Four-state sequencer: idle, issue pulse, wait for bus, completion pulse.
// Assumes bus_done is only meaningful in the wait state.
module pci_seq_ctrl
    import pci_sel_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       req_valid,
    input  logic       reject,
    input  logic       bus_done,
    output seq_state_e state,
    output logic       accept,
    output logic       capture,
    output logic       start,
    output logic       cpl,
    output logic       ready
);
    seq_state_e nxt;

    // Decode strobes from the current state.
    always_comb begin
        ready   = (state == ST_IDLE);
        accept  = ready && req_valid;
        capture = (state == ST_WAIT) && bus_done;
        start   = (state == ST_ISSUE);
        cpl     = (state == ST_CPL);
    end

    // Next-state selection.
    always_comb begin
        nxt = state;
        case (state)
            ST_IDLE:  if (accept) nxt = reject ? ST_CPL : ST_ISSUE;
            ST_ISSUE: nxt = ST_WAIT;
            ST_WAIT:  if (bus_done) nxt = ST_CPL;
            default:  nxt = ST_IDLE;
        endcase
    end

    // State register with synchronous reset.
    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= nxt;
    end

    AST_START_AFTER_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && !reject) |=> start); // R10
    AST_REJECT_SKIPS_BUS: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && reject) |=> (cpl && !start)); // R7

endmodule

// File: rtl/pci_cpl_build.sv
// Module: pci_cpl_build
// Registers the host completion: error flag and read data, including the
// all-ones substitution for unanswered configuration reads.
module pci_cpl_build #(
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reject_load,
    input  logic              capture,
    input  logic              is_read,
    input  logic              is_cfg_rd,
    input  logic              berr_en_q,
    input  logic              noresp,
    input  logic [DATA_W-1:0] rdata,
    output logic              cpl_err,
    output logic [DATA_W-1:0] cpl_rdata
);
    logic              err_d;
    logic [DATA_W-1:0] data_d;

    // Outcome rules for a bus result.
    always_comb begin
        err_d  = 1'b0;
        data_d = '0;
        if (noresp) begin
            if (is_cfg_rd && !berr_en_q) data_d = '1;
            else                         err_d  = 1'b1;
        end else if (is_read) begin
            data_d = rdata;
        end
    end

    // Completion registers, loaded on refusal or on bus outcome.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cpl_err   <= 1'b0;
            cpl_rdata <= '0;
        end else if (reject_load) begin
            cpl_err   <= 1'b1;
            cpl_rdata <= '0;
        end else if (capture) begin
            cpl_err   <= err_d;
            cpl_rdata <= data_d;
        end
    end

    AST_ONES_ONLY_UNREPORTED: assert property (@(posedge clk) disable iff (!rst_n)
        (capture && noresp && !(is_cfg_rd && !berr_en_q)) |=> cpl_err); // R11

endmodule

// File: rtl/pci_cmd_selector.sv
// Module: pci_cmd_selector (top)
// Accepts one host request at a time, latches the command and settings,
// runs one bus cycle and returns a completion. Assumes the bus engine
// raises bus_done exactly once per bus_start.
module pci_cmd_selector
    import pci_sel_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int ADDR_W = 32,
    parameter int WCNT_W = 9,
    parameter int CLS_W  = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic [2:0]        req_kind,
    input  logic [WCNT_W-1:0] req_words,
    input  logic [ADDR_W-1:0] req_addr,
    output logic              req_ready,
    input  logic              cfg_mwi_en,
    input  logic [CLS_W-1:0]  cfg_line_size,
    input  logic              cfg_host_mode,
    input  logic              cfg_berr_en,
    output logic              bus_start,
    output logic [3:0]        bus_cmd,
    output logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_done,
    input  logic              bus_noresp,
    input  logic [DATA_W-1:0] bus_rdata,
    output logic              cpl_valid,
    output logic              cpl_err,
    output logic [DATA_W-1:0] cpl_rdata
);
    cmd_sel_t          sel_now;
    cmd_sel_t          sel_q;
    logic              berr_q;
    logic [ADDR_W-1:0] addr_q;
    seq_state_e        state;
    logic              accept;
    logic              capture;

    pci_cmd_decode #(.WCNT_W(WCNT_W), .CLS_W(CLS_W)) u_dec (
        .kind      (req_kind),
        .words     (req_words),
        .mwi_en    (cfg_mwi_en),
        .line_size (cfg_line_size),
        .host_mode (cfg_host_mode),
        .sel       (sel_now)
    );

    pci_seq_ctrl u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .req_valid (req_valid),
        .reject    (sel_now.reject),
        .bus_done  (bus_done),
        .state     (state),
        .accept    (accept),
        .capture   (capture),
        .start     (bus_start),
        .cpl       (cpl_valid),
        .ready     (req_ready)
    );

    // Latch the selection, address and reporting enable at acceptance.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sel_q  <= '0;
            berr_q <= 1'b1;
            addr_q <= '0;
        end else if (accept) begin
            sel_q  <= sel_now;
            berr_q <= cfg_berr_en;
            addr_q <= req_addr;
        end
    end

    // Bus-side outputs come straight from the latched request.
    always_comb begin
        bus_cmd  = sel_q.cmd;
        bus_addr = addr_q;
    end

    pci_cpl_build #(.DATA_W(DATA_W)) u_cpl (
        .clk         (clk),
        .rst_n       (rst_n),
        .reject_load (accept && sel_now.reject),
        .capture     (capture),
        .is_read     (sel_q.is_read),
        .is_cfg_rd   (sel_q.is_cfg_rd),
        .berr_en_q   (berr_q),
        .noresp      (bus_noresp),
        .rdata       (bus_rdata),
        .cpl_err     (cpl_err),
        .cpl_rdata   (cpl_rdata)
    );

    AST_START_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        bus_start |=> !bus_start); // R10
    AST_CPL_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        cpl_valid |=> !cpl_valid); // R10
    AST_BUSY_NOT_READY: assert property (@(posedge clk) disable iff (!rst_n)
        bus_start |-> !req_ready); // R10
    AST_MWI_NEEDS_ENABLE: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_start && bus_cmd == CMD_MWI) |->
            ($past(cfg_mwi_en) && $past(cfg_line_size) != '0)); // R2
    AST_IACK_HOST_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_start && bus_cmd == CMD_IACK) |-> $past(cfg_host_mode)); // R6
    AST_CMD_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_WAIT) |-> $stable(bus_cmd)); // R12

endmodule

// File: tb/pci_cmd_selector_tb.sv
module pci_cmd_selector_tb_top;
    logic        clk = 1'b0;
    logic        rst_n;
    logic        req_valid;
    logic [2:0]  req_kind;
    logic [8:0]  req_words;
    logic [31:0] req_addr;
    logic        req_ready;
    logic        cfg_mwi_en;
    logic [7:0]  cfg_line_size;
    logic        cfg_host_mode;
    logic        cfg_berr_en;
    logic        bus_start;
    logic [3:0]  bus_cmd;
    logic [31:0] bus_addr;
    logic        bus_done;
    logic        bus_noresp;
    logic [31:0] bus_rdata;
    logic        cpl_valid;
    logic        cpl_err;
    logic [31:0] cpl_rdata;

    int total = 0;
    int bad   = 0;
    bit finished = 0;

    always #5 clk = ~clk;

    pci_cmd_selector dut_i (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_kind(req_kind),
        .req_words(req_words), .req_addr(req_addr), .req_ready(req_ready),
        .cfg_mwi_en(cfg_mwi_en), .cfg_line_size(cfg_line_size),
        .cfg_host_mode(cfg_host_mode), .cfg_berr_en(cfg_berr_en),
        .bus_start(bus_start), .bus_cmd(bus_cmd), .bus_addr(bus_addr),
        .bus_done(bus_done), .bus_noresp(bus_noresp), .bus_rdata(bus_rdata),
        .cpl_valid(cpl_valid), .cpl_err(cpl_err), .cpl_rdata(cpl_rdata)
    );

    task automatic check(input bit ok, input string tag, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s %s: actual=%h expected=%h", tag, what, act, exp);
        end
    endtask

    // Expected command from the requirements R2..R6.
    function automatic logic [3:0] exp_cmd(input logic [2:0] k, input logic [8:0] w,
                                           input logic mwi, input logic [7:0] ls);
        case (k)
            3'd0: return 4'h6;
            3'd1: return (mwi && ls != 0 && w > {1'b0, ls}) ? 4'hF : 4'h7;
            3'd2: return 4'hA;
            3'd3: return 4'hB;
            default: return 4'h0;
        endcase
    endfunction

    // One full bus transaction with checks at issue and completion.
    task automatic txn(input string tag, input logic [2:0] k, input logic [8:0] w,
                       input logic [31:0] a, input logic mwi, input logic [7:0] ls,
                       input logic berr, input logic nr, input logic [31:0] rd,
                       input bit flip);
        logic [3:0]  ec;
        logic        ee;
        logic [31:0] ed;
        ec = exp_cmd(k, w, mwi, ls);
        @(negedge clk);
        req_valid = 1; req_kind = k; req_words = w; req_addr = a;
        cfg_mwi_en = mwi; cfg_line_size = ls; cfg_host_mode = 1; cfg_berr_en = berr;
        @(posedge clk);
        @(negedge clk);
        req_valid = 0;
        check(bus_start === 1'b1, "R10", "start after accept", 32'(bus_start), 1);
        check(req_ready === 1'b0, "R10", "ready low while busy", 32'(req_ready), 0);
        check(bus_cmd === ec, tag, "command", 32'(bus_cmd), 32'(ec));
        check(bus_addr === a, tag, "address", bus_addr, a);
        @(posedge clk);
        @(negedge clk);
        check(bus_start === 1'b0, "R10", "start one cycle", 32'(bus_start), 0);
        if (flip) begin
            cfg_mwi_en = ~mwi; cfg_line_size = ~ls; cfg_berr_en = ~berr;
            req_words = ~w;
            @(posedge clk);
            @(negedge clk);
            check(bus_cmd === ec, "R12", "cmd held after setting change", 32'(bus_cmd), 32'(ec));
            check(cpl_valid === 1'b0, "R10", "no early completion", 32'(cpl_valid), 0);
        end
        bus_done = 1; bus_noresp = nr; bus_rdata = rd;
        @(posedge clk);
        @(negedge clk);
        bus_done = 0; bus_noresp = 0; bus_rdata = 0;
        if (nr) begin
            ee = !(k == 3'd2 && !berr);
            ed = ee ? 32'h0 : 32'hFFFF_FFFF;
        end else begin
            ee = 0;
            ed = (k == 3'd0 || k == 3'd2 || k == 3'd4) ? rd : 32'h0;
        end
        check(cpl_valid === 1'b1, "R10", "completion pulse", 32'(cpl_valid), 1);
        check(cpl_err === ee, tag, "cpl_err", 32'(cpl_err), 32'(ee));
        check(cpl_rdata === ed, tag, "cpl_rdata", cpl_rdata, ed);
        @(posedge clk);
        @(negedge clk);
        check(cpl_valid === 1'b0 && req_ready === 1'b1, "R10", "back to idle",
              {30'b0, cpl_valid, req_ready}, 32'b01);
    endtask

    // Refused request: no bus cycle, error completion next cycle.
    task automatic refuse(input logic [2:0] k, input logic host);
        @(negedge clk);
        req_valid = 1; req_kind = k; req_words = 1; req_addr = 32'h40;
        cfg_host_mode = host;
        @(posedge clk);
        @(negedge clk);
        req_valid = 0;
        check(bus_start === 1'b0, "R7", "no bus start on refusal", 32'(bus_start), 0);
        check(cpl_valid === 1'b1 && cpl_err === 1'b1, "R7", "error completion",
              {30'b0, cpl_valid, cpl_err}, 32'b11);
        check(cpl_rdata === 32'h0, "R7", "zero data", cpl_rdata, 0);
        @(posedge clk);
        @(negedge clk);
        check(bus_start === 1'b0 && req_ready === 1'b1, "R7", "idle after refusal",
              {30'b0, bus_start, req_ready}, 32'b01);
        cfg_host_mode = 1;
    endtask

    task automatic test_reset();
        @(negedge clk);
        check(req_ready === 1'b1, "R1", "ready at reset", 32'(req_ready), 1);
        check(bus_start === 1'b0, "R1", "start at reset", 32'(bus_start), 0);
        check(cpl_valid === 1'b0, "R1", "cpl at reset", 32'(cpl_valid), 0);
    endtask

    initial begin : watchdog
        repeat (20000) @(posedge clk);
        if (!finished) begin
            total++; bad++;
            $display("FAIL watchdog: actual=timeout expected=done");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        rst_n = 0; req_valid = 0; req_kind = 0; req_words = 0; req_addr = 0;
        cfg_mwi_en = 0; cfg_line_size = 0; cfg_host_mode = 1; cfg_berr_en = 1;
        bus_done = 0; bus_noresp = 0; bus_rdata = 0;
        repeat (3) @(posedge clk);
        test_reset();
        rst_n = 1;
        test_reset();
        txn("R2", 3'd1, 9'd9,   32'h1000, 1, 8'd8, 1, 0, 0, 0);
        txn("R2", 3'd1, 9'd256, 32'h1100, 1, 8'd255, 1, 0, 0, 0);
        txn("R3", 3'd1, 9'd8,   32'h1200, 1, 8'd8, 1, 0, 0, 0);
        txn("R3", 3'd1, 9'd20,  32'h1300, 1, 8'd0, 1, 0, 0, 0);
        txn("R3", 3'd1, 9'd20,  32'h1400, 0, 8'd4, 1, 0, 0, 0);
        txn("R4", 3'd0, 9'd20,  32'h2000, 1, 8'd0, 1, 0, 32'hCAFE_0001, 0);
        txn("R4", 3'd0, 9'd20,  32'h2100, 1, 8'd8, 1, 0, 32'hCAFE_0002, 0);
        txn("R5", 3'd2, 9'd1,   32'h0008_0810, 0, 8'd0, 1, 0, 32'h1234_5678, 0);
        txn("R5", 3'd3, 9'd1,   32'h00A1_0811, 0, 8'd0, 1, 0, 0, 0);
        txn("R6", 3'd4, 9'd1,   32'h0,    0, 8'd0, 1, 0, 32'h0000_0021, 0);
        refuse(3'd4, 1'b0);
        refuse(3'd6, 1'b1);
        txn("R8", 3'd2, 9'd1,   32'h0010_0000, 0, 8'd0, 1, 1, 32'h5555_5555, 0);
        txn("R9", 3'd2, 9'd1,   32'h0010_0000, 0, 8'd0, 0, 1, 32'h5555_5555, 0);
        txn("R11", 3'd0, 9'd4,  32'h3000, 0, 8'd0, 0, 1, 32'h7, 0);
        txn("R11", 3'd3, 9'd1,  32'h0020_0001, 0, 8'd0, 0, 1, 0, 0);
        txn("R11", 3'd4, 9'd1,  32'h0, 0, 8'd0, 0, 1, 0, 0);
        txn("R12", 3'd1, 9'd9,  32'h4000, 1, 8'd8, 1, 0, 0, 1);
        txn("R12", 3'd2, 9'd1,  32'h0030_0000, 0, 8'd0, 1, 1, 0, 1);
        finished = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule